// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block audits one set of a set-associative data cache. On a start request it reads the tag of every way in that set through a single-cycle tag read port, going from way 0 upward. For each way it produces:

- the 5-bit coherence state,
- whether that state is a legal resident-line encoding,
- the rebuilt physical line address.

It also checks the two parity bits that protect the physical tag of each resident line. Errors are collected into two sticky flags, one for illegal states and one for tag-address parity. Both flags are cleared by the next accepted start. The replacement-order byte of the set is captured from way 0.

An error handler uses it after a cache error is reported. It points the checker at the suspect set and reads back a short report. The report has one strobe per way, a state flag, an address flag, the replacement byte and a done pulse.

Top module: `dc_tag_audit`

## Requirements
- R1: After reset, `done`, `way_vld`, `rd_en`, `err_state`, `err_addr` and `lru` are all zero.
- R2: An accepted start issues exactly one read per way, in ascending way order, with `rd_addr` = (way << 13) | set index. No two reads occur in consecutive cycles.
- R3: Each way is reported by a one-cycle `way_vld` strobe, in ascending order. The strobe carries `way_id` and `way_state`, which is tag-high bits 29:25.
- R4: `way_valid` is high only for the five codes 5'h0F, 5'h13, 5'h19, 5'h16 and 5'h1C.
- R5: `err_state` is set when any scanned way holds a code other than those five. This includes code 5'h00.
- R6: For a way with a legal state, tag-low bit 11 must equal the XOR of tag-low bits 39:26. A mismatch sets `err_addr`.
- R7: For a way with a legal state, tag-low bit 10 must equal the XOR of tag-low bits 25:13. A mismatch sets `err_addr`.
- R8: A way whose state is not legal never sets `err_addr`, whatever its parity bits hold.
- R9: `way_pa` equals tag-low bits 39:13 above the 13-bit set index.
- R10: `lru` takes tag-high bits 21:14 of way 0 at way 0's strobe and holds that value at all other times.
- R11: Both error flags clear in the cycle after a start is accepted. They then accumulate across the four ways and hold after `done`.
- R12: `done` is a single-cycle pulse that coincides with the strobe of the last way.
- R13: A start that arrives while a scan is running is ignored. The scan keeps its set index and no second scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted when idle) |
| set_idx | input | 13 | Set index to scan |
| rd_en | output | 1 | Tag read request |
| rd_addr | output | 15 | Tag read address: way above index |
| rd_tag_hi | input | 32 | Tag high word, valid the cycle after `rd_en` |
| rd_tag_lo | input | 64 | Tag low word, valid the cycle after `rd_en` |
| way_vld | output | 1 | Per-way report strobe |
| way_id | output | 2 | Way being reported |
| way_state | output | 5 | Coherence state code |
| way_valid | output | 1 | State is a legal resident-line code |
| way_pa | output | 40 | Rebuilt physical line address |
| err_state | output | 1 | Sticky illegal-state flag |
| err_addr | output | 1 | Sticky tag parity flag |
| lru | output | 8 | Replacement-order byte of way 0 |
| done | output | 1 | Scan complete pulse |

## Verification
The assertions assume that the tag port returns data exactly one cycle after each read request, and that `start` is a clean level from a synchronous source. The bench meets both conditions. Its memory model latches the request address at the clock edge and presents the tag words during the following cycle. `start` is only ever driven at the falling edge. The bench also pulses `start` again in the middle of a scan, which exercises the acceptance rule without breaking the port timing.

// File: rtl/dc_tag_audit_pkg.sv
package dc_tag_audit_pkg;

   localparam int unsigned STATE_W    = 5;
   localparam int unsigned NUM_LEGAL  = 5;

   // coherence codes that mark a resident line
   localparam logic [STATE_W-1:0] LEGAL_CODES [NUM_LEGAL] = '{
      5'h0F,   // shared, coherent
      5'h13,   // exclusive clean, non-coherent
      5'h19,   // exclusive dirty, non-coherent
      5'h16,   // exclusive clean, coherent
      5'h1C    // exclusive dirty, coherent
   };

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_REQ  = 2'd1,
      WK_CHK  = 2'd2
   } walk_state_e;

endpackage

// File: rtl/dc_tag_decode.sv
module dc_tag_decode
   import dc_tag_audit_pkg::*;
#(
   parameter int unsigned HI_W       = 32,
   parameter int unsigned LO_W       = 64,
   parameter int unsigned IDX_W      = 13,
   parameter int unsigned PA_W       = 40,
   parameter int unsigned TAG_LSB    = 13,
   parameter int unsigned SPLIT      = 26,
   parameter int unsigned PAR_HI_BIT = 11,
   parameter int unsigned PAR_LO_BIT = 10,
   parameter int unsigned STATE_LSB  = 25
) (
   input  logic [HI_W-1:0]    tag_hi,
   input  logic [LO_W-1:0]    tag_lo,
   input  logic [IDX_W-1:0]   idx,
   output logic [STATE_W-1:0] state,
   output logic               legal,
   output logic               par_err,
   output logic [PA_W-1:0]    pa
);

   logic [NUM_LEGAL-1:0] hit;
   logic                 hi_par;
   logic                 lo_par;

   assign state = tag_hi[STATE_LSB +: STATE_W];

   for (genvar g = 0; g < NUM_LEGAL; g++) begin : g_code
      assign hit[g] = (state == LEGAL_CODES[g]);
   end

   assign legal  = |hit;

   // even parity over each half of the physical tag
   assign hi_par = ^tag_lo[PA_W-1:SPLIT];
   assign lo_par = ^tag_lo[SPLIT-1:TAG_LSB];

   assign par_err = legal & ((tag_lo[PAR_HI_BIT] ^ hi_par) |
                             (tag_lo[PAR_LO_BIT] ^ lo_par));

   assign pa = {tag_lo[PA_W-1:TAG_LSB], idx};

endmodule

// File: rtl/dc_tag_walker.sv
module dc_tag_walker
   import dc_tag_audit_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = 13,
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int unsigned ADDR_W = WAY_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  set_idx,
   output logic              accept,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              chk_en,
   output logic [WAY_W-1:0]  chk_way,
   output logic              last,
   output logic [IDX_W-1:0]  idx_q
);

   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

   walk_state_e      st;
   logic [WAY_W-1:0] way;

   assign accept  = start && (st == WK_IDLE);
   assign rd_en   = (st == WK_REQ);
   assign rd_addr = {way, idx_q};
   assign chk_en  = (st == WK_CHK);
   assign chk_way = way;
   assign last    = (way == LAST_WAY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WK_IDLE;
         way   <= '0;
         idx_q <= '0;
      end else begin
         unique case (st)
            WK_IDLE: if (start) begin
               idx_q <= set_idx;
               way   <= '0;
               st    <= WK_REQ;
            end
            WK_REQ:  st <= WK_CHK;
            WK_CHK: begin
               if (last) st <= WK_IDLE;
               else begin
                  way <= way + 1'b1;
                  st  <= WK_REQ;
               end
            end
            default: st <= WK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dc_tag_audit.sv
module dc_tag_audit
   import dc_tag_audit_pkg::*;
#(
   parameter int unsigned WAYS       = 4,
   parameter int unsigned IDX_W      = 13,
   parameter int unsigned HI_W       = 32,
   parameter int unsigned LO_W       = 64,
   parameter int unsigned PA_W       = 40,
   parameter int unsigned TAG_LSB    = 13,
   parameter int unsigned SPLIT      = 26,
   parameter int unsigned PAR_HI_BIT = 11,
   parameter int unsigned PAR_LO_BIT = 10,
   parameter int unsigned STATE_LSB  = 25,
   parameter int unsigned LRU_LSB    = 14,
   parameter int unsigned LRU_W      = 8,
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int unsigned ADDR_W = WAY_W + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IDX_W-1:0]     set_idx,
   output logic                 rd_en,
   output logic [ADDR_W-1:0]    rd_addr,
   input  logic [HI_W-1:0]      rd_tag_hi,
   input  logic [LO_W-1:0]      rd_tag_lo,
   output logic                 way_vld,
   output logic [WAY_W-1:0]     way_id,
   output logic [STATE_W-1:0]   way_state,
   output logic                 way_valid,
   output logic [PA_W-1:0]      way_pa,
   output logic                 err_state,
   output logic                 err_addr,
   output logic [LRU_W-1:0]     lru,
   output logic                 done
);

   // elaboration-time parameter checks
   if (IDX_W != TAG_LSB) begin : g_bad_idx
      $error("set index width must equal the physical tag LSB");
   end
   if (!(TAG_LSB < SPLIT && SPLIT < PA_W && PA_W <= LO_W)) begin : g_bad_split
      $error("tag split must lie inside the physical tag");
   end
   if (STATE_LSB + STATE_W > HI_W || LRU_LSB + LRU_W > HI_W) begin : g_bad_hi
      $error("state or LRU field exceeds tag-high width");
   end
   if (PAR_HI_BIT >= TAG_LSB || PAR_LO_BIT >= TAG_LSB) begin : g_bad_par
      $error("parity bits must lie below the physical tag");
   end

   logic               accept;
   logic               chk_en;
   logic [WAY_W-1:0]   chk_way;
   logic               last;
   logic [IDX_W-1:0]   idx_q;
   logic [STATE_W-1:0] dec_state;
   logic               dec_legal;
   logic               dec_par_err;
   logic [PA_W-1:0]    dec_pa;

   dc_tag_walker #(
      .WAYS  (WAYS),
      .IDX_W (IDX_W)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .set_idx (set_idx),
      .accept  (accept),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .chk_en  (chk_en),
      .chk_way (chk_way),
      .last    (last),
      .idx_q   (idx_q)
   );

   dc_tag_decode #(
      .HI_W       (HI_W),
      .LO_W       (LO_W),
      .IDX_W      (IDX_W),
      .PA_W       (PA_W),
      .TAG_LSB    (TAG_LSB),
      .SPLIT      (SPLIT),
      .PAR_HI_BIT (PAR_HI_BIT),
      .PAR_LO_BIT (PAR_LO_BIT),
      .STATE_LSB  (STATE_LSB)
   ) u_dec (
      .tag_hi  (rd_tag_hi),
      .tag_lo  (rd_tag_lo),
      .idx     (idx_q),
      .state   (dec_state),
      .legal   (dec_legal),
      .par_err (dec_par_err),
      .pa      (dec_pa)
   );

   logic unused_bits;
   assign unused_bits = ^{rd_tag_hi, rd_tag_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         way_vld   <= 1'b0;
         way_id    <= '0;
         way_state <= '0;
         way_valid <= 1'b0;
         way_pa    <= '0;
         err_state <= 1'b0;
         err_addr  <= 1'b0;
         lru       <= '0;
         done      <= 1'b0;
      end else begin
         way_vld <= chk_en;
         done    <= chk_en && last;
         if (accept) begin
            err_state <= 1'b0;
            err_addr  <= 1'b0;
         end else if (chk_en) begin
            err_state <= err_state | ~dec_legal;
            err_addr  <= err_addr  | dec_par_err;
         end
         if (chk_en) begin
            way_id    <= chk_way;
            way_state <= dec_state;
            way_valid <= dec_legal;
            way_pa    <= dec_pa;
            if (chk_way == '0) lru <= rd_tag_hi[LRU_LSB +: LRU_W];
         end
      end
   end

endmodule

// File: rtl/dc_tag_audit_chk.sv
module dc_tag_audit_chk #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned LRU_W = 8,
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             rd_en,
   input logic             way_vld,
   input logic [WAY_W-1:0] way_id,
   input logic             way_valid,
   input logic             err_state,
   input logic [LRU_W-1:0] lru,
   input logic             done
);

   // R2: reads are never back to back
   assert_read_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   // R3: way strobes follow in ascending order, two cycles apart
   assert_way_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (way_vld && way_id != '0) |-> ($past(way_vld, 2) && $past(way_id, 2) == way_id - 1'b1));

   // R5: an illegal way report always leaves the state flag set
   assert_state_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (way_vld && !way_valid) |-> err_state);

   // R10: replacement byte only moves at way 0's report
   assert_lru_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(way_vld && way_id == '0) |-> $stable(lru));

   // R11: the state flag only drops after a start request
   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_state) |-> $past(start));

   // R12: done marks the last way's report and lasts one cycle
   assert_done_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (way_vld && way_id == WAY_W'(WAYS - 1)));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind dc_tag_audit dc_tag_audit_chk #(
   .WAYS  (WAYS),
   .LRU_W (LRU_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .rd_en     (rd_en),
   .way_vld   (way_vld),
   .way_id    (way_id),
   .way_valid (way_valid),
   .err_state (err_state),
   .lru       (lru),
   .done      (done)
);

// File: tb/tb_dc_tag_audit.sv
`timescale 1ns/1ps
module tb_dc_tag_audit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [12:0] set_idx = '0;
   logic        rd_en;
   logic [14:0] rd_addr;
   logic [31:0] rd_tag_hi;
   logic [63:0] rd_tag_lo;
   logic        way_vld;
   logic [1:0]  way_id;
   logic [4:0]  way_state;
   logic        way_valid;
   logic [39:0] way_pa;
   logic        err_state;
   logic        err_addr;
   logic [7:0]  lru;
   logic        done;

   always #2.5 clk = ~clk;

   dc_tag_audit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .set_idx(set_idx),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_tag_hi(rd_tag_hi), .rd_tag_lo(rd_tag_lo),
      .way_vld(way_vld), .way_id(way_id), .way_state(way_state), .way_valid(way_valid),
      .way_pa(way_pa), .err_state(err_state), .err_addr(err_addr), .lru(lru), .done(done)
   );

   // tag memory model: one-cycle read latency
   logic [31:0] mem_hi [4];
   logic [63:0] mem_lo [4];
   logic [1:0]  lat_way = '0;
   always @(posedge clk) if (rd_en) lat_way <= rd_addr[14:13];
   assign rd_tag_hi = mem_hi[lat_way];
   assign rd_tag_lo = mem_lo[lat_way];

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit legal(input logic [4:0] s);
      return s == 5'h0F || s == 5'h13 || s == 5'h19 || s == 5'h16 || s == 5'h1C;
   endfunction

   function automatic logic [63:0] mk_lo(input int seed, input bit flip_h, input bit flip_l);
      logic [63:0] v;
      v = {32'hA5C3_1E77 * seed[31:0], 32'h9E37_79B9 * (seed[31:0] + 32'd3)};
      v[11] = (^v[39:26]) ^ flip_h;
      v[10] = (^v[25:13]) ^ flip_l;
      return v;
   endfunction

   function automatic logic [31:0] mk_hi(input int seed, input logic [4:0] s);
      logic [31:0] v;
      v = 32'h6C07_8965 * (seed[31:0] + 32'd11);
      v[29:25] = s;
      return v;
   endfunction

   // run one scan; poke issues a second start mid-scan (R13)
   task automatic run_set(input logic [12:0] idx, input bit poke, input string tag);
      bit exp_es, exp_ea, ok_done;
      int strobes, reads;
      exp_es = 0;
      exp_ea = 0;
      for (int w = 0; w < 4; w++) begin
         logic [4:0] s;
         s = mem_hi[w][29:25];
         if (!legal(s)) exp_es = 1;
         else if ((mem_lo[w][11] != ^mem_lo[w][39:26]) ||
                  (mem_lo[w][10] != ^mem_lo[w][25:13])) exp_ea = 1;
      end
      @(negedge clk);
      set_idx = idx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R11: flags clear right after acceptance
      chk(err_state == 0 && err_addr == 0, "R11 clear", {err_state, err_addr}, 0);
      strobes = 0;
      reads = 0;
      ok_done = 0;
      for (int c = 0; c < 16 && !ok_done; c++) begin
         if (poke && c == 3) begin
            set_idx = ~idx;
            start = 1'b1;
         end else start = 1'b0;
         if (rd_en) begin
            chk(rd_addr == {reads[1:0], idx}, "R2 addr", rd_addr, {reads[1:0], idx});
            reads++;
         end
         if (way_vld) begin
            logic [4:0] s;
            s = mem_hi[strobes][29:25];
            chk(way_id == strobes[1:0], "R3 way id", way_id, strobes);
            chk(way_state == s, "R3 state", way_state, s);
            chk(way_valid == legal(s), "R4 valid", way_valid, legal(s));
            chk(way_pa == {mem_lo[strobes][39:13], idx}, "R9 pa", way_pa,
                {mem_lo[strobes][39:13], idx});
            if (strobes == 0)
               chk(lru == mem_hi[0][21:14], "R10 lru", lru, mem_hi[0][21:14]);
            chk(done == (strobes == 3), "R12 done", done, strobes == 3);
            strobes++;
            if (done) ok_done = 1;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(strobes == 4 && reads == 4, {"R2 R3 counts ", tag}, strobes * 16 + reads, 68);
      chk(err_state == exp_es, {"R5 err_state ", tag}, err_state, exp_es);
      chk(err_addr == exp_ea, {"R6 R7 R8 err_addr ", tag}, err_addr, exp_ea);
      chk(done == 0, "R12 single pulse", done, 0);
      // R13 and R10: no second scan, report held
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(!way_vld && !rd_en, "R13 no rescan", {way_vld, rd_en}, 0);
      end
      chk(lru == mem_hi[0][21:14], "R10 hold", lru, mem_hi[0][21:14]);
      chk(err_state == exp_es && err_addr == exp_ea, "R11 hold",
          {err_state, err_addr}, {exp_es, exp_ea});
   endtask

   initial begin
      #50000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   logic [4:0] good_codes [5] = '{5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};

   initial begin
      for (int w = 0; w < 4; w++) begin
         mem_hi[w] = '0;
         mem_lo[w] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !way_vld && !rd_en && !err_state && !err_addr && lru == 0,
          "R1 reset", {done, way_vld, rd_en, err_state, err_addr, lru}, 0);
      rst_n = 1'b1;

      // all 32 state codes, parity faults on some runs (R4 R5 R6 R7 R8)
      for (int r = 0; r < 8; r++) begin
         for (int w = 0; w < 4; w++) begin
            mem_hi[w] = mk_hi(r * 4 + w, 5'(r * 4 + w));
            mem_lo[w] = mk_lo(r * 7 + w, (r % 2 == 1) && (w == r % 4),
                              (r % 2 == 1) && (w == (r + 1) % 4));
         end
         run_set(13'(r * 613 + 5), 0, "sweep");
      end

      // all legal, good parity, then a single fault in each half per way
      for (int f = 0; f < 9; f++) begin
         for (int w = 0; w < 4; w++) begin
            mem_hi[w] = mk_hi(100 + f * 4 + w, good_codes[(f + w) % 5]);
            mem_lo[w] = mk_lo(200 + f * 4 + w, f > 0 && f <= 4 && w == f - 1,
                              f > 4 && w == f - 5);
         end
         run_set(13'(f * 911 + 1), f == 2, "legal");
      end

      // R8: invalid ways with bad parity; R11: flags clear from a dirty run
      for (int w = 0; w < 4; w++) begin
         mem_hi[w] = mk_hi(300 + w, (w == 2) ? 5'h1C : 5'h00);
         mem_lo[w] = mk_lo(400 + w, w != 2, w != 2);
      end
      run_set(13'h1FFF, 1, "invalid-bad-par");
      for (int w = 0; w < 4; w++) begin
         mem_hi[w] = mk_hi(500 + w, 5'h0F);
         mem_lo[w] = mk_lo(600 + w, 0, 0);
      end
      run_set(13'h0000, 0, "clean");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule